// File: doc/BRIEF.md
# Dynamic Voltage Scaling Set-Point Sequencer

This block drives the 5-bit voltage code of one buck regulator output. Three programmable operating codes are held at its inputs: a run code, an alternate (performance) code and a sleep code. A pin requesting the alternate level and a pair of sleep inputs choose which of the three codes is the target. Sleep is in force only when both sleep inputs are high, and it then wins over the pin.

The code sent to the regulator never jumps. Whenever the target differs from the present output, the output moves one code at a time toward it. Each step is separated by a programmable number of clock cycles. Every kind of target change ramps at this same rate: a pin edge, entering or leaving sleep, or a new value written to the code that is currently selected. A settled flag tells the rest of the system when the output has arrived.

Top module: `dvs_setpoint_seq`

## Requirements
- R1: When `sleep_req_a` and `sleep_req_b` are both 1, the target is `sleep_code`, whatever the level of `alt_sel`.
- R2: When sleep is not in force, the target is `run_code` if `alt_sel` is 0 and `alt_code` if `alt_sel` is 1.
- R3: Only one of the two sleep inputs being high has no effect: the target stays as R2 gives it, and the output does not move.
- R4: Each change of `vout_code` is exactly one code, in the direction of the target code that applied in the cycle before.
- R5: With step interval N (`step_intv`, with 0 treated as 1), a ramp that starts from rest and covers d codes takes exactly d*N rising clock edges. The first step lands on the N-th edge after the target changes.
- R6: Writing a new value to the selected code ramps to it at the programmed rate and does not jump.
- R7: If the target changes during a ramp, the output continues from its present code toward the new target without being reloaded.
- R8: `settled` is 1 exactly when `vout_code` equals the target. While it is 1, `vout_code` does not change.
- R9: While `rst` is high, `vout_code` loads `run_code` directly. After reset, `settled` is 1 if the inputs still select `run_code`.
- R10: Ramps work in both directions across the full range 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_code | input | 5 | Code for normal operation |
| alt_code | input | 5 | Code selected by the alternate-level pin |
| sleep_code | input | 5 | Code used while sleep is in force |
| step_intv | input | 8 | Clock cycles between steps (0 acts as 1) |
| alt_sel | input | 1 | Pin requesting the alternate code |
| sleep_req_a | input | 1 | First sleep condition |
| sleep_req_b | input | 1 | Second sleep condition, ANDed with the first |
| vout_code | output | 5 | Code driven to the regulator |
| settled | output | 1 | High when the output equals the target |

## Verification
The assertions check on every cycle that the output moves by at most one code, and only toward the target of the previous cycle. They also check that it holds still while settled, that it loads the run code out of reset, and that a settled output matches the code chosen by the priority of sleep over the pin over normal. The exact spacing of steps, and the treatment of an interval of zero, can only be shown by the bench's scenarios, which count edges per ramp. The same holds for continuing from the present code after a reversal in mid-ramp and for the ramp that follows a write to the selected code.

// File: rtl/dvs_seq_pkg.sv
package dvs_seq_pkg;

    // Which operating point is currently the target
    typedef enum logic [1:0] {
        PT_RUN   = 2'd0,
        PT_ALT   = 2'd1,
        PT_SLEEP = 2'd2
    } point_sel_e;

    // Direction of the next step
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

    // Sleep is in force only when both conditions hold
    function automatic logic sleep_active(input logic a, input logic b);
        return a & b;
    endfunction

    // Priority: sleep, then pin, then normal
    function automatic point_sel_e pick_point(input logic sleep_on, input logic pin);
        if (sleep_on)
            return PT_SLEEP;
        else if (pin)
            return PT_ALT;
        else
            return PT_RUN;
    endfunction

endpackage

// File: rtl/dvs_target_sel.sv
module dvs_target_sel
    import dvs_seq_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] run_code,
    input  logic [CODE_W-1:0] alt_code,
    input  logic [CODE_W-1:0] sleep_code,
    input  logic              alt_sel,
    input  logic              sleep_req_a,
    input  logic              sleep_req_b,
    output point_sel_e        point,
    output logic [CODE_W-1:0] target
);

    logic sleep_on;

    always_comb begin
        sleep_on = sleep_active(sleep_req_a, sleep_req_b);
        point    = pick_point(sleep_on, alt_sel);
        unique case (point)
            PT_SLEEP: target = sleep_code;
            PT_ALT:   target = alt_code;
            default:  target = run_code;
        endcase
    end

endmodule

// File: rtl/dvs_step_timer.sv
module dvs_step_timer #(
    parameter int INTV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [INTV_W-1:0] intv,
    output logic              tick
);

    logic [INTV_W-1:0] cnt;
    logic [INTV_W-1:0] last;

    always_comb begin
        // An interval of zero behaves as one cycle
        last = (intv == '0) ? '0 : intv - 1'b1;
        tick = run && (cnt >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/dvs_ramp_reg.sv
module dvs_ramp_reg
    import dvs_seq_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] init_code,
    input  logic [CODE_W-1:0] target,
    input  logic              tick,
    output logic [CODE_W-1:0] code,
    output step_dir_e         dir,
    output logic              at_target
);

    always_comb begin
        if (target > code)
            dir = DIR_UP;
        else if (target < code)
            dir = DIR_DOWN;
        else
            dir = DIR_HOLD;
        at_target = (dir == DIR_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst)
            code <= init_code;
        else if (tick) begin
            unique case (dir)
                DIR_UP:   code <= code + 1'b1;
                DIR_DOWN: code <= code - 1'b1;
                default:  code <= code;
            endcase
        end
    end

endmodule

// File: rtl/dvs_setpoint_seq.sv
module dvs_setpoint_seq
    import dvs_seq_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int INTV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] run_code,
    input  logic [CODE_W-1:0] alt_code,
    input  logic [CODE_W-1:0] sleep_code,
    input  logic [INTV_W-1:0] step_intv,
    input  logic              alt_sel,
    input  logic              sleep_req_a,
    input  logic              sleep_req_b,
    output logic [CODE_W-1:0] vout_code,
    output logic              settled
);

    point_sel_e        point;
    step_dir_e         dir;
    logic [CODE_W-1:0] target_code;
    logic              step_tick;

    dvs_target_sel #(.CODE_W(CODE_W)) u_sel (
        .run_code    (run_code),
        .alt_code    (alt_code),
        .sleep_code  (sleep_code),
        .alt_sel     (alt_sel),
        .sleep_req_a (sleep_req_a),
        .sleep_req_b (sleep_req_b),
        .point       (point),
        .target      (target_code)
    );

    dvs_step_timer #(.INTV_W(INTV_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (!settled),
        .intv (step_intv),
        .tick (step_tick)
    );

    dvs_ramp_reg #(.CODE_W(CODE_W)) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .init_code (run_code),
        .target    (target_code),
        .tick      (step_tick),
        .code      (vout_code),
        .dir       (dir),
        .at_target (settled)
    );

endmodule

// File: rtl/dvs_setpoint_chk.sv
module dvs_setpoint_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] run_code,
    input logic [CODE_W-1:0] alt_code,
    input logic [CODE_W-1:0] sleep_code,
    input logic              alt_sel,
    input logic              sleep_req_a,
    input logic              sleep_req_b,
    input logic [CODE_W-1:0] vout_code,
    input logic              settled,
    input logic [CODE_W-1:0] target_code
);

    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vout_code == $past(vout_code) ||
                  vout_code == $past(vout_code) + 1'b1 ||
                  vout_code == $past(vout_code) - 1'b1));

    assert_up_toward_R4: assert property (@(posedge clk) disable iff (rst)
        (target_code > vout_code) |=> (vout_code >= $past(vout_code)));

    assert_down_toward_R4: assert property (@(posedge clk) disable iff (rst)
        (target_code < vout_code) |=> (vout_code <= $past(vout_code)));

    assert_hold_settled_R8: assert property (@(posedge clk) disable iff (rst)
        settled |=> (vout_code == $past(vout_code)));

    assert_sleep_wins_R1: assert property (@(posedge clk) disable iff (rst)
        (sleep_req_a && sleep_req_b && settled) |-> (vout_code == sleep_code));

    assert_alt_pick_R2: assert property (@(posedge clk) disable iff (rst)
        (!(sleep_req_a && sleep_req_b) && alt_sel && settled) |-> (vout_code == alt_code));

    assert_run_pick_R3: assert property (@(posedge clk) disable iff (rst)
        (!(sleep_req_a && sleep_req_b) && !alt_sel && settled) |-> (vout_code == run_code));

    assert_reset_load_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vout_code == $past(run_code)));

endmodule

bind dvs_setpoint_seq dvs_setpoint_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .run_code    (run_code),
    .alt_code    (alt_code),
    .sleep_code  (sleep_code),
    .alt_sel     (alt_sel),
    .sleep_req_a (sleep_req_a),
    .sleep_req_b (sleep_req_b),
    .vout_code   (vout_code),
    .settled     (settled),
    .target_code (target_code)
);

// File: tb/sim_dvs_setpoint_seq.sv
module sim_dvs_setpoint_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] run_code = 5'd10;
    logic [4:0] alt_code = 5'd20;
    logic [4:0] sleep_code = 5'd3;
    logic [7:0] step_intv = 8'd3;
    logic       alt_sel = 1'b0;
    logic       sleep_req_a = 1'b0;
    logic       sleep_req_b = 1'b0;
    logic [4:0] vout_code;
    logic       settled;

    int n_checks = 0;
    int n_fail = 0;
    int edges = 0;

    always #5 clk = ~clk;

    dvs_setpoint_seq u0 (
        .clk         (clk),
        .rst         (rst),
        .run_code    (run_code),
        .alt_code    (alt_code),
        .sleep_code  (sleep_code),
        .step_intv   (step_intv),
        .alt_sel     (alt_sel),
        .sleep_req_a (sleep_req_a),
        .sleep_req_b (sleep_req_b),
        .vout_code   (vout_code),
        .settled     (settled)
    );

    typedef struct packed {
        logic [4:0] run_c;
        logic [4:0] alt_c;
        logic [4:0] sleep_c;
        logic [7:0] intv;
        logic       pin;
        logic       sa;
        logic       sb;
        logic [4:0] exp_code;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{5'd10, 5'd20, 5'd3, 8'd3, 1'b1, 1'b0, 1'b0, 5'd20}, // R2 pin high -> alt
        '{5'd10, 5'd20, 5'd3, 8'd3, 1'b1, 1'b1, 1'b0, 5'd20}, // R3 one sleep input only
        '{5'd10, 5'd20, 5'd3, 8'd1, 1'b1, 1'b1, 1'b1, 5'd3},  // R1 sleep over pin
        '{5'd10, 5'd25, 5'd3, 8'd1, 1'b0, 1'b1, 1'b1, 5'd3},  // R1 alt change ignored
        '{5'd10, 5'd25, 5'd3, 8'd2, 1'b0, 1'b0, 1'b1, 5'd10}, // R2 leave sleep -> run
        '{5'd31, 5'd25, 5'd3, 8'd1, 1'b0, 1'b0, 1'b0, 5'd31}, // R6 R10 write up to top
        '{5'd0,  5'd25, 5'd3, 8'd0, 1'b0, 1'b0, 1'b0, 5'd0},  // R5 R10 interval 0, to bottom
        '{5'd0,  5'd25, 5'd3, 8'd4, 1'b1, 1'b0, 1'b0, 5'd25}  // R5 R2 slow ramp up
    };

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        edges++;
        if (edges > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", edges, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Walk a ramp: count edges until settled, checking each move
    task automatic run_ramp(input string req, input logic [4:0] exp_code, input int exp_cyc);
        int cyc = 0;
        logic shape_ok = 1'b1;
        logic [4:0] prev;
        prev = vout_code;
        while (!settled && cyc < 2000) begin
            @(posedge clk); #1;
            cyc++;
            if (vout_code != prev) begin
                if (!((exp_code > prev && vout_code == prev + 5'd1) ||
                      (exp_code < prev && vout_code == prev - 5'd1)))
                    shape_ok = 1'b0;
            end
            prev = vout_code;
        end
        check({req, " R4 step shape"}, shape_ok, vout_code, exp_code);
        check({req, " final code"}, vout_code == exp_code, vout_code, exp_code);
        check({req, " R5 edge count"}, cyc == exp_cyc, cyc, exp_cyc);
    endtask

    initial begin
        logic [4:0] model;
        // R9: reset loads run code directly
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset code", vout_code == 5'd10, vout_code, 10);
        rst = 1'b0;
        @(negedge clk);
        check("R9 settled after reset", settled == 1'b1, settled, 1);
        check("R9 no ramp after reset", vout_code == 5'd10, vout_code, 10);
        model = 5'd10;

        for (int i = 0; i < NVEC; i++) begin
            int d;
            int n;
            @(negedge clk);
            run_code    = VECS[i].run_c;
            alt_code    = VECS[i].alt_c;
            sleep_code  = VECS[i].sleep_c;
            step_intv   = VECS[i].intv;
            alt_sel     = VECS[i].pin;
            sleep_req_a = VECS[i].sa;
            sleep_req_b = VECS[i].sb;
            #1;
            d = (VECS[i].exp_code > model) ? int'(VECS[i].exp_code) - int'(model)
                                           : int'(model) - int'(VECS[i].exp_code);
            n = (VECS[i].intv == 8'd0) ? 1 : int'(VECS[i].intv);
            if (d != 0)
                check("R8 busy while apart", settled == 1'b0, settled, 0);
            run_ramp($sformatf("vec%0d", i), VECS[i].exp_code, d * n);
            check("R8 settled at end", settled == 1'b1, settled, 1);
            model = VECS[i].exp_code;
        end

        // R6 R7: write run code and reverse mid-ramp; from 25 drop pin -> run 0? set run 10 first
        @(negedge clk);
        run_code = 5'd20;
        alt_sel = 1'b0;
        step_intv = 8'd2;
        // 25 -> 20 at interval 2 takes 10 edges
        #1;
        run_ramp("R6 write down", 5'd20, 10);
        @(negedge clk);
        run_code = 5'd30;  // R6: ramp, not jump
        #1;
        check("R6 no jump", vout_code == 5'd20, vout_code, 20);
        repeat (6) @(posedge clk);
        #1;
        check("R7 three steps in", vout_code == 5'd23, vout_code, 23);
        @(negedge clk);
        run_code = 5'd5;   // reverse mid-ramp
        repeat (2) @(posedge clk);
        #1;
        check("R7 continues from present", vout_code == 5'd22, vout_code, 22);
        run_ramp("R7 reverse", 5'd5, 34);

        // R3: other single sleep input, output must not move
        @(negedge clk);
        sleep_req_a = 1'b0;
        sleep_req_b = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check("R3 single input ignored", vout_code == 5'd5 && settled, vout_code, 5);

        // R9: reset mid-ramp loads run code at once
        @(negedge clk);
        alt_sel = 1'b1;
        alt_code = 5'd31;
        step_intv = 8'd1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        alt_sel = 1'b0;
        run_code = 5'd17;
        rst = 1'b1;
        @(posedge clk); #1;
        check("R9 mid-ramp reset", vout_code == 5'd17, vout_code, 17);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 settled", settled == 1'b1, settled, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule